// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog built around a 64-bit up-counter and a 64-bit limit. Software reaches it through a small word-addressed write bus with a combinational read path. Before the watchdog can be armed, a configuration word must select the 64-bit watchdog mode. Arming then takes two steps: a control write that sets the enable bit and carries the first key, then a write that carries the second key.

Once active, the watchdog is serviced by writing the first key and then the second key, which clears the counter. Any other key written while active, or while a service is half done, raises a reset request at once. The request is also raised if the counter reaches the limit while the watchdog is active. The request is a one-cycle pulse. After it, the watchdog falls back to its idle state, with the enable bit clear and the counter at zero.

Address map (word addresses on `bus_addr`): 0 counter low half, 1 counter high half, 2 limit low half, 3 limit high half, 4 configuration (bits 3:0), 5 watchdog control. A control write carries the key in bits 31:16 and the enable in bit 14. A control read returns the enable in bit 14 and the state code in bits 13:12 (0 idle, 1 pre-active, 2 active, 3 service pending); all other bits read 0. The key values are 0xA5C6 (first) and 0xDA7E (second).

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset, `wd_rst_req` is 0, the control word reads 0x0000_0000, the configuration reads 0, the counter reads 0 and the limit reads all ones.
- R2: In the idle state, a control write with bit 14 set and key 0xA5C6, while the configuration is 0xB, moves the watchdog to pre-active (control reads 0x0000_5000). In idle and pre-active, every control write loads bit 14 into the enable.
- R3: If the configuration is not 0xB, a control write with key 0xA5C6 and bit 14 set leaves the state idle (control reads 0x0000_4000).
- R4: In pre-active, key 0xDA7E with bit 14 set moves the watchdog to active (control reads 0x0000_6000). Other keys with bit 14 set leave it in pre-active and raise no reset request.
- R5: While active or service pending, writes to the configuration, the limit and the counter are ignored, and the enable bit stays 1 whatever bit 14 of a control write holds.
- R6: While active, key 0xA5C6 moves the watchdog to service pending (control reads 0x0000_7000). Key 0xDA7E then returns it to active and clears the counter to 0 on the same edge.
- R7: While active, a key other than 0xA5C6 raises `wd_rst_req` on the clock edge that takes the write. While service pending, a key other than 0xDA7E does the same.
- R8: While active, if the counter equals the limit on a clock edge, `wd_rst_req` rises on the following edge. After a service completes on edge P, the request is therefore first seen after edge P+L+1, where L is the limit.
- R9: `wd_rst_req` is high for exactly one cycle. While it is high, the control word reads 0 and the counter reads 0.
- R10: When the configuration is 0xB, the counter counts up by one per cycle. Outside the active states, it wraps to 0 on the edge after it equals the limit.
- R11: In pre-active, a control write with bit 14 clear returns the watchdog to idle with the enable clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wd_rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest condition to reach from the ports is an expiry in exactly the right cycle. The bench must configure the mode, set a short limit and zero the counter while all of these are still writable. It must then arm and service the watchdog, and only after that count cycles up to the pulse. The bench does this in that order and polls the output on every falling edge to confirm the exact cycle of the request. Invalid keys are drawn at random, with the valid key removed from the draw, in both the active and the service-pending states, and the watchdog is re-armed after each reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int KEY_LSB = 16;
    localparam int EN_BIT  = 14;

    localparam logic [15:0] KEY_FIRST  = 16'hA5C6;
    localparam logic [15:0] KEY_SECOND = 16'hDA7E;
    localparam logic [3:0]  CFG_WD_READY = 4'hB;

    localparam logic [2:0] A_CNT_LO = 3'd0;
    localparam logic [2:0] A_CNT_HI = 3'd1;
    localparam logic [2:0] A_LIM_LO = 3'd2;
    localparam logic [2:0] A_LIM_HI = 3'd3;
    localparam logic [2:0] A_CFG    = 3'd4;
    localparam logic [2:0] A_CTL    = 3'd5;

    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_PRE     = 2'd1,
        WD_ACTIVE  = 2'd2,
        WD_SERVICE = 2'd3
    } wd_state_e;

    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic lim_lo;
        logic lim_hi;
        logic cfg;
        logic ctl;
    } wr_sel_t;

    function automatic logic is_locked(wd_state_e s);
        return (s == WD_ACTIVE) || (s == WD_SERVICE);
    endfunction

    function automatic logic [DATA_W-1:0] ctl_word(logic en, wd_state_e s);
        return {16'h0000, 1'b0, en, s, 12'h000};
    endfunction
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          locked,
    input  logic [CW-1:0] cnt,
    input  wd_state_e     state,
    input  logic          en,
    output wr_sel_t       sel,
    output logic [CW-1:0] lim,
    output logic          mode_ok,
    output logic [DW-1:0] rdata
);
    logic [3:0] cfg;

    always_comb begin
        sel = '0;
        if (bus_wr) begin
            unique case (bus_addr)
                A_CNT_LO: sel.cnt_lo = !locked;
                A_CNT_HI: sel.cnt_hi = !locked;
                A_LIM_LO: sel.lim_lo = !locked;
                A_LIM_HI: sel.lim_hi = !locked;
                A_CFG:    sel.cfg    = !locked;
                A_CTL:    sel.ctl    = 1'b1;
                default:  sel        = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lim <= '1;
            cfg <= '0;
        end else begin
            if (sel.lim_lo) lim[DW-1:0]  <= bus_wdata;
            if (sel.lim_hi) lim[CW-1:DW] <= bus_wdata;
            if (sel.cfg)    cfg          <= bus_wdata[3:0];
        end
    end

    assign mode_ok = (cfg == CFG_WD_READY);

    always_comb begin
        unique case (bus_addr)
            A_CNT_LO: rdata = cnt[DW-1:0];
            A_CNT_HI: rdata = cnt[CW-1:DW];
            A_LIM_LO: rdata = lim[DW-1:0];
            A_LIM_HI: rdata = lim[CW-1:DW];
            A_CFG:    rdata = {{(DW-4){1'b0}}, cfg};
            A_CTL:    rdata = ctl_word(en, state);
            default:  rdata = '0;
        endcase
    end

    // R5
    cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(cfg) && $stable(lim));
endmodule

// File: rtl/wdg_count64.sv
module wdg_count64
    import wdg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic [DW-1:0] wdata,
    input  logic          clr,
    input  logic [CW-1:0] lim,
    output logic [CW-1:0] cnt,
    output logic          hit
);
    assign hit = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (ld_lo || ld_hi) begin
            if (ld_lo) cnt[DW-1:0]  <= wdata;
            if (ld_hi) cnt[CW-1:DW] <= wdata;
        end else if (run) begin
            cnt <= hit ? '0 : cnt + 1'b1;
        end
    end

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));
    // R10
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !clr && !ld_lo && !ld_hi && !hit) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/wdg_keyfsm.sv
module wdg_keyfsm
    import wdg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_we,
    input  logic [15:0] key,
    input  logic        en_bit,
    input  logic        mode_ok,
    input  logic        hit,
    output wd_state_e   state,
    output logic        en,
    output logic        rst_req,
    output logic        clr
);
    wd_state_e state_n;
    logic      en_n;
    logic      fire;
    logic      svc_done;

    always_comb begin
        state_n  = state;
        en_n     = en;
        fire     = 1'b0;
        svc_done = 1'b0;
        unique case (state)
            WD_IDLE: if (ctl_we) begin
                en_n = en_bit;
                if (en_bit && key == KEY_FIRST && mode_ok) state_n = WD_PRE;
            end
            WD_PRE: if (ctl_we) begin
                en_n = en_bit;
                if (!en_bit)                state_n = WD_IDLE;
                else if (key == KEY_SECOND) state_n = WD_ACTIVE;
            end
            WD_ACTIVE: begin
                if (hit)                                fire = 1'b1;
                else if (ctl_we && key == KEY_FIRST)    state_n = WD_SERVICE;
                else if (ctl_we)                        fire = 1'b1;
            end
            WD_SERVICE: begin
                if (hit)                                fire = 1'b1;
                else if (ctl_we && key == KEY_SECOND) begin
                    state_n  = WD_ACTIVE;
                    svc_done = 1'b1;
                end else if (ctl_we)                    fire = 1'b1;
            end
            default: state_n = WD_IDLE;
        endcase
        if (fire) begin
            state_n = WD_IDLE;
            en_n    = 1'b0;
        end
    end

    assign clr = fire || svc_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= WD_IDLE;
            en      <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            state   <= state_n;
            en      <= en_n;
            rst_req <= fire;
        end
    end

    // R9
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);
    // R9
    back_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (state == WD_IDLE) && !en);
    // R5
    en_locked_chk: assert property (@(posedge clk) disable iff (rst)
        is_locked(state) |-> en);
    // R4
    active_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == WD_ACTIVE && !is_locked($past(state))) |-> ($past(state) == WD_PRE));
endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
    import wdg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic [2:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          wd_rst_req
);
    wr_sel_t       sel;
    logic [CW-1:0] lim;
    logic [CW-1:0] cnt;
    logic          mode_ok;
    logic          hit;
    logic          clr;
    logic          en;
    wd_state_e     state;

    wdg_regs #(.DW(DW), .CW(CW)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .locked(is_locked(state)), .cnt(cnt),
        .state(state), .en(en), .sel(sel), .lim(lim), .mode_ok(mode_ok),
        .rdata(bus_rdata)
    );

    wdg_count64 #(.DW(DW), .CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .run(mode_ok), .ld_lo(sel.cnt_lo),
        .ld_hi(sel.cnt_hi), .wdata(bus_wdata), .clr(clr), .lim(lim),
        .cnt(cnt), .hit(hit)
    );

    wdg_keyfsm u_fsm (
        .clk(clk), .rst(rst), .ctl_we(sel.ctl),
        .key(bus_wdata[KEY_LSB +: 16]), .en_bit(bus_wdata[EN_BIT]),
        .mode_ok(mode_ok), .hit(hit), .state(state), .en(en),
        .rst_req(wd_rst_req), .clr(clr)
    );

    // R7
    bad_key_chk: assert property (@(posedge clk) disable iff (rst)
        (state == WD_ACTIVE && sel.ctl && bus_wdata[KEY_LSB +: 16] != KEY_FIRST) |=> wd_rst_req);
endmodule

// File: tb/tb_wdg_keyed_top.sv
module tb_wdg_keyed_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_CLO = 3'd0, A_CHI = 3'd1, A_LLO = 3'd2,
                           A_LHI = 3'd3, A_CFGR = 3'd4, A_CTLR = 3'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        wd_rst_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdg_keyed_top dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_rst_req(wd_rst_req)
    );

    function automatic logic [31:0] exp_ctl(logic en, logic [1:0] st);
        return (32'(en) << 14) | (32'(st) << 12);
    endfunction

    function automatic logic [15:0] key_not(logic [15:0] k, logic [15:0] avoid);
        return (k == avoid) ? ~avoid : k;
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic arm();
        wr(A_CTLR, 32'hA5C6_4000);
        wr(A_CTLR, 32'hDA7E_4000);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [15:0] k;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        #1; chk("R1 rst_req", 64'(wd_rst_req), 64'd0);
        rd(A_CTLR, d); chk("R1 ctl", 64'(d), 64'h0);
        rd(A_CFGR, d); chk("R1 cfg", 64'(d), 64'h0);
        rd(A_CLO, d);  chk("R1 cnt", 64'(d), 64'h0);
        rd(A_LHI, d);  chk("R1 lim", 64'(d), 64'hFFFF_FFFF);

        // R3 arming refused without watchdog mode
        wr(A_CTLR, 32'hA5C6_4000);
        rd(A_CTLR, d); chk("R3 no mode", 64'(d), 64'(exp_ctl(1'b1, 2'd0)));

        // R10 counting and wrap
        wr(A_LLO, 32'd5);
        wr(A_LHI, 32'd0);
        wr(A_CFGR, 32'hB);
        rd(A_CLO, d); chk("R10 start", 64'(d), 64'd0);
        for (int n = 1; n <= 7; n++) begin
            @(negedge clk);
            rd(A_CLO, d); chk("R10 count", 64'(d), 64'(n % 6));
        end

        wr(A_LLO, 32'd1000);
        wr(A_CLO, 32'd0);

        // R2 / R4 arming
        wr(A_CTLR, 32'h0000_4000);
        rd(A_CTLR, d); chk("R2 enable", 64'(d), 64'(exp_ctl(1'b1, 2'd0)));
        wr(A_CTLR, 32'hA5C6_4000);
        rd(A_CTLR, d); chk("R2 pre", 64'(d), 64'(exp_ctl(1'b1, 2'd1)));
        for (int n = 0; n < 5; n++) begin
            k = key_not(16'($urandom), 16'hDA7E);
            wr(A_CTLR, {k, 16'h4000});
            rd(A_CTLR, d); chk("R4 stray key", 64'(d), 64'(exp_ctl(1'b1, 2'd1)));
            chk("R4 no req", 64'(wd_rst_req), 64'd0);
        end
        wr(A_CTLR, 32'hDA7E_4000);
        rd(A_CTLR, d); chk("R4 active", 64'(d), 64'(exp_ctl(1'b1, 2'd2)));

        // R5 locks
        wr(A_CFGR, 32'h0);
        rd(A_CFGR, d); chk("R5 cfg", 64'(d), 64'hB);
        wr(A_LLO, 32'd3);
        rd(A_LLO, d); chk("R5 lim", 64'(d), 64'd1000);
        wr(A_CHI, 32'h55);
        rd(A_CHI, d); chk("R5 cnt", 64'(d), 64'd0);

        // R6 service, enable bit written 0 (R5)
        wr(A_CTLR, 32'hA5C6_0000);
        rd(A_CTLR, d); chk("R6 pending", 64'(d), 64'(exp_ctl(1'b1, 2'd3)));
        wr(A_CTLR, 32'hDA7E_0000);
        rd(A_CTLR, d); chk("R6 back active", 64'(d), 64'(exp_ctl(1'b1, 2'd2)));
        rd(A_CLO, d);  chk("R6 cleared", 64'(d), 64'd0);

        // R7 / R9 invalid key while active
        for (int n = 0; n < 4; n++) begin
            k = key_not(16'($urandom), 16'hA5C6);
            wr(A_CTLR, {k, 16'h4000});
            #1; chk("R7 req", 64'(wd_rst_req), 64'd1);
            rd(A_CTLR, d); chk("R9 idle", 64'(d), 64'h0);
            rd(A_CLO, d);  chk("R9 cnt", 64'(d), 64'd0);
            @(negedge clk);
            #1; chk("R9 one cycle", 64'(wd_rst_req), 64'd0);
            arm();
            rd(A_CTLR, d); chk("R4 rearm", 64'(d), 64'(exp_ctl(1'b1, 2'd2)));
        end

        // R7 invalid second key during service
        wr(A_CTLR, 32'hA5C6_4000);
        k = key_not(16'($urandom), 16'hDA7E);
        wr(A_CTLR, {k, 16'h4000});
        #1; chk("R7 service req", 64'(wd_rst_req), 64'd1);

        // R8 expiry at limit 20
        wr(A_LLO, 32'd20);
        wr(A_CLO, 32'd0);
        arm();
        wr(A_CTLR, 32'hA5C6_4000);
        wr(A_CTLR, 32'hDA7E_4000);
        for (int n = 1; n <= 21; n++) begin
            @(negedge clk);
            #1; chk("R8 expiry", 64'(wd_rst_req), (n == 21) ? 64'd1 : 64'd0);
        end
        @(negedge clk);
        rd(A_CTLR, d); chk("R9 after expiry", 64'(d), 64'h0);

        // R11 disable from pre-active
        wr(A_CTLR, 32'hA5C6_4000);
        wr(A_CTLR, 32'h0000_0000);
        rd(A_CTLR, d); chk("R11 idle", 64'(d), 64'h0);
        chk("R11 no req", 64'(wd_rst_req), 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule